// File: doc/BRIEF.md
# Outstanding Miss Tracker for a Shared Non-Blocking Cache

This block keeps one record per outstanding line fill of a shared non-blocking cache. An accepted miss either joins a record already open for the same line or opens a new one in the lowest free slot. A new record stores the line address and the requester, and one cycle later the block sends a fill read downstream, tagged with the slot index. If the miss also evicts a dirty line, the block emits a write-back request in the same cycle as that fill read. A fill response names its slot. One cycle later the block reports the line and every requester that waited on it, and the slot becomes free again.

The block also drives a single stall for the whole cache. The stall is raised while every slot is in use or while the external write-back buffer reports full. During a stall no request is taken from any requester, hits included. The cache resumes only when both structures have room. The number of slots sets how many misses can be outstanding at once. Private caches typically use about six slots, and shared caches about eleven to nineteen.

Top module: `mshr_file`

## Requirements
- R1: After reset every slot is free, `block_o` is low, `req_ready_o` is high and `fill_valid_o`, `wb_valid_o` and `retire_valid_o` are low.
- R2: An accepted miss (`req_miss_i`=1) whose line has no open slot opens the lowest-numbered free slot. In the next cycle `fill_valid_o` is high, with that index on `fill_idx_o` and the line on `fill_line_o`.
- R3: An accepted miss whose line matches an open slot does not open a new slot and raises no fill. Its requester is added to that slot's waiter set.
- R4: A fill response naming an open slot makes `retire_valid_o` high in the next cycle. `retire_idx_o` gives the slot, `retire_line_o` its line, and `retire_srcs_o` a bit mask with bit k set for each requester k that waited on it. The slot is free from that cycle on.
- R5: A fill response naming a free slot, or an index of N_ENTRIES or above, is ignored: no retirement is reported and no slot changes.
- R6: `block_o` is high exactly when all slots are open or `wb_full_i` is high. `req_ready_o` is its inverse, and a request presented while blocked opens nothing and merges nothing.
- R7: An accepted hit (`req_miss_i`=0) changes no slot and raises no fill or write-back.
- R8: A miss that opens a slot with `req_wb_i`=1 makes `wb_valid_o` high in the next cycle, with `req_victim_i` on `wb_line_o`. A merged miss never raises a write-back.
- R9: When the slots are full and `wb_full_i` is high, freeing a slot does not clear `block_o` while the buffer is still full. The stall ends only once both have space.
- R10: A miss arriving in the same cycle as the retiring response of a slot holding the same line opens a new slot instead of joining the retiring one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle when valid |
| req_miss_i | input | 1 | 1 = miss, 0 = hit |
| req_line_i | input | LINE_W | Line address of the request |
| req_src_i | input | $clog2(N_SRC) | Requester number |
| req_wb_i | input | 1 | Miss evicts a dirty line |
| req_victim_i | input | LINE_W | Line address of the evicted dirty line |
| wb_full_i | input | 1 | External write-back buffer has no room |
| block_o | output | 1 | Cache-wide stall |
| fill_valid_o | output | 1 | Fill read issued downstream |
| fill_idx_o | output | $clog2(N_ENTRIES) | Slot tagging the fill read |
| fill_line_o | output | LINE_W | Line to fetch |
| wb_valid_o | output | 1 | Write-back issued downstream |
| wb_line_o | output | LINE_W | Line to write back |
| fill_rsp_valid_i | input | 1 | Fill data returned |
| fill_rsp_idx_i | input | $clog2(N_ENTRIES) | Slot the returned fill belongs to |
| retire_valid_o | output | 1 | A slot was closed |
| retire_idx_o | output | $clog2(N_ENTRIES) | Closed slot |
| retire_line_o | output | LINE_W | Line of the closed slot |
| retire_srcs_o | output | N_SRC | Requesters that waited on the line |

## Verification
Every wrong slot state shows at the ports. A stale valid bit raises `block_o` one fill too early, or opens a slot at an index other than the lowest free one, and this is visible at the next `fill_idx_o`. A lost waiter bit or a wrong stored line first appears when that slot retires, one cycle after its response. The bench therefore drains every slot it opens. A merge into the wrong slot shows up either as a missing fill one cycle after the miss or as a wrong mask at retirement.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  localparam int unsigned DEF_ENTRIES = 6;
  localparam int unsigned DEF_LINE_W  = 16;
  localparam int unsigned DEF_SRC     = 4;
endpackage

// File: rtl/mshr_pick_free.sv
module mshr_pick_free #(
  parameter int unsigned N  = 6,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  free_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mshr_match.sv
module mshr_match #(
  parameter int unsigned N  = 6,
  parameter int unsigned LW = 16,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]         live_i,
  input  logic [N-1:0][LW-1:0] lines_i,
  input  logic [LW-1:0]        line_i,
  output logic                 hit_o,
  output logic [IW-1:0]        hit_idx_o
);
  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = live_i[g] && (lines_i[g] == line_i);
  end

  // at most one live slot per line, so plain encode suffices
  always_comb begin
    hit_o     = |eq;
    hit_idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (eq[i]) hit_idx_o = hit_idx_o | IW'(i);
    end
  end
endmodule

// File: rtl/mshr_file.sv
module mshr_file
  import mshr_pkg::*;
#(
  parameter int unsigned N_ENTRIES = DEF_ENTRIES,
  parameter int unsigned LINE_W    = DEF_LINE_W,
  parameter int unsigned N_SRC     = DEF_SRC,
  localparam int unsigned IW       = $clog2(N_ENTRIES),
  localparam int unsigned SW       = $clog2(N_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_miss_i,
  input  logic [LINE_W-1:0] req_line_i,
  input  logic [SW-1:0]     req_src_i,
  input  logic              req_wb_i,
  input  logic [LINE_W-1:0] req_victim_i,
  input  logic              wb_full_i,
  output logic              block_o,
  output logic              fill_valid_o,
  output logic [IW-1:0]     fill_idx_o,
  output logic [LINE_W-1:0] fill_line_o,
  output logic              wb_valid_o,
  output logic [LINE_W-1:0] wb_line_o,
  input  logic              fill_rsp_valid_i,
  input  logic [IW-1:0]     fill_rsp_idx_i,
  output logic              retire_valid_o,
  output logic [IW-1:0]     retire_idx_o,
  output logic [LINE_W-1:0] retire_line_o,
  output logic [N_SRC-1:0]  retire_srcs_o
);
  logic [N_ENTRIES-1:0]             valid_q;
  logic [N_ENTRIES-1:0][LINE_W-1:0] line_q;
  logic [N_ENTRIES-1:0][N_SRC-1:0]  mask_q;

  logic                 rsp_in_range, rsp_ok;
  logic [N_ENTRIES-1:0] retire_vec, live;
  logic                 full, accept, miss_acc, merge, alloc;
  logic                 hit, found;
  logic [IW-1:0]        hit_idx, free_idx;
  logic [N_SRC-1:0]     src_bit;

  assign rsp_in_range = ({1'b0, fill_rsp_idx_i} < (IW+1)'(N_ENTRIES));
  assign rsp_ok       = fill_rsp_valid_i && rsp_in_range && valid_q[fill_rsp_idx_i];

  always_comb begin
    retire_vec = '0;
    if (rsp_ok) retire_vec[fill_rsp_idx_i] = 1'b1;
  end

  // retiring slot may not absorb a new waiter
  assign live = valid_q & ~retire_vec;

  assign full        = &valid_q;
  assign block_o     = full | wb_full_i;
  assign req_ready_o = ~block_o;

  assign accept   = req_valid_i && !block_o;
  assign miss_acc = accept && req_miss_i;
  assign merge    = miss_acc && hit;
  assign alloc    = miss_acc && !hit && found;
  assign src_bit  = N_SRC'(1) << req_src_i;

  mshr_match #(.N(N_ENTRIES), .LW(LINE_W), .IW(IW)) u_match (
    .live_i    (live),
    .lines_i   (line_q),
    .line_i    (req_line_i),
    .hit_o     (hit),
    .hit_idx_o (hit_idx)
  );

  mshr_pick_free #(.N(N_ENTRIES), .IW(IW)) u_pick (
    .free_i  (~valid_q),
    .found_o (found),
    .idx_o   (free_idx)
  );

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        line_q[g]  <= '0;
        mask_q[g]  <= '0;
      end else if (alloc && free_idx == IW'(g)) begin
        valid_q[g] <= 1'b1;
        line_q[g]  <= req_line_i;
        mask_q[g]  <= src_bit;
      end else begin
        if (retire_vec[g]) valid_q[g] <= 1'b0;
        if (merge && hit_idx == IW'(g)) mask_q[g] <= mask_q[g] | src_bit;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_valid_o   <= 1'b0;
      fill_idx_o     <= '0;
      fill_line_o    <= '0;
      wb_valid_o     <= 1'b0;
      wb_line_o      <= '0;
      retire_valid_o <= 1'b0;
      retire_idx_o   <= '0;
      retire_line_o  <= '0;
      retire_srcs_o  <= '0;
    end else begin
      fill_valid_o   <= alloc;
      wb_valid_o     <= alloc && req_wb_i;
      retire_valid_o <= rsp_ok;
      if (alloc) begin
        fill_idx_o  <= free_idx;
        fill_line_o <= req_line_i;
        wb_line_o   <= req_victim_i;
      end
      if (rsp_ok) begin
        retire_idx_o  <= fill_rsp_idx_i;
        retire_line_o <= line_q[fill_rsp_idx_i];
        retire_srcs_o <= mask_q[fill_rsp_idx_i];
      end
    end
  end
endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
  parameter int unsigned N_ENTRIES = 6,
  parameter int unsigned LINE_W    = 16,
  parameter int unsigned N_SRC     = 4,
  localparam int unsigned IW       = $clog2(N_ENTRIES),
  localparam int unsigned SW       = $clog2(N_SRC)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              req_miss_i,
  input logic [LINE_W-1:0] req_line_i,
  input logic [SW-1:0]     req_src_i,
  input logic              req_wb_i,
  input logic [LINE_W-1:0] req_victim_i,
  input logic              wb_full_i,
  input logic              block_o,
  input logic              fill_valid_o,
  input logic [IW-1:0]     fill_idx_o,
  input logic [LINE_W-1:0] fill_line_o,
  input logic              wb_valid_o,
  input logic [LINE_W-1:0] wb_line_o,
  input logic              fill_rsp_valid_i,
  input logic [IW-1:0]     fill_rsp_idx_i,
  input logic              retire_valid_o,
  input logic [IW-1:0]     retire_idx_o,
  input logic [LINE_W-1:0] retire_line_o,
  input logic [N_SRC-1:0]  retire_srcs_o
);
  p_wb_full_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_full_i |-> !req_ready_o);

  p_no_fill_when_blocked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_o |=> !fill_valid_o);

  p_fill_from_miss_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o |-> $past(req_valid_i && req_miss_i && req_ready_o));

  p_hit_no_fill_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_miss_i) |=> !fill_valid_o && !wb_valid_o);

  p_wb_with_fill_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> fill_valid_o && $past(req_wb_i));

  p_retire_from_rsp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_valid_o |-> $past(fill_rsp_valid_i) && retire_srcs_o != '0);

  p_retire_idx_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_valid_o |-> retire_idx_o == $past(fill_rsp_idx_i));
endmodule

bind mshr_file mshr_file_chk #(
  .N_ENTRIES(N_ENTRIES), .LINE_W(LINE_W), .N_SRC(N_SRC)
) u_chk (.*);

// File: tb/mshr_file_bench.sv
`timescale 1ns/1ps
module mshr_file_bench;
  localparam int N  = 6;
  localparam int LW = 16;
  localparam int NS = 4;
  localparam int IW = $clog2(N);
  localparam int SW = $clog2(NS);

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid = 0, req_miss = 0, req_wb = 0, wb_full = 0;
  logic [LW-1:0] req_line = 0, req_victim = 0;
  logic [SW-1:0] req_src = 0;
  logic          rsp_valid = 0;
  logic [IW-1:0] rsp_idx = 0;
  logic          ready, block, fill_v, wb_v, ret_v;
  logic [IW-1:0] fill_idx, ret_idx;
  logic [LW-1:0] fill_line, wb_line, ret_line;
  logic [NS-1:0] ret_srcs;

  mshr_file #(.N_ENTRIES(N), .LINE_W(LW), .N_SRC(NS)) u_mshr_file (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(ready), .req_miss_i(req_miss),
    .req_line_i(req_line), .req_src_i(req_src), .req_wb_i(req_wb),
    .req_victim_i(req_victim), .wb_full_i(wb_full), .block_o(block),
    .fill_valid_o(fill_v), .fill_idx_o(fill_idx), .fill_line_o(fill_line),
    .wb_valid_o(wb_v), .wb_line_o(wb_line),
    .fill_rsp_valid_i(rsp_valid), .fill_rsp_idx_i(rsp_idx),
    .retire_valid_o(ret_v), .retire_idx_o(ret_idx),
    .retire_line_o(ret_line), .retire_srcs_o(ret_srcs)
  );

  int checks = 0, fails = 0;
  bit m_valid[N];
  int m_line[N];
  int m_mask[N];

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check stall, step model, check registered outputs
  task automatic cyc(string tag, bit v, bit miss, int line, int src, bit wb,
                     int victim, bit rv, int ridx, bit wf);
    bit e_block, acc, rok, mt, fnd, e_fill, e_wb;
    int mi, fi, e_rline, e_rmask;
    req_valid = v; req_miss = miss; req_line = LW'(line); req_src = SW'(src);
    req_wb = wb; req_victim = LW'(victim); rsp_valid = rv; rsp_idx = IW'(ridx);
    wb_full = wf;
    #1;
    e_block = wf;
    begin
      bit all = 1;
      for (int i = 0; i < N; i++) if (!m_valid[i]) all = 0;
      e_block |= all;
    end
    chk({tag, "/R6"}, "block_o", block, e_block);
    chk({tag, "/R6"}, "req_ready_o", ready, !e_block);
    rok = rv && ridx < N && m_valid[ridx];
    e_rline = rok ? m_line[ridx] : 0;
    e_rmask = rok ? m_mask[ridx] : 0;
    acc = v && !e_block;
    mt = 0; mi = 0;
    for (int i = 0; i < N; i++)
      if (m_valid[i] && !(rok && i == ridx) && m_line[i] == line) begin mt = 1; mi = i; end
    fnd = 0; fi = 0;
    for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) begin fnd = 1; fi = i; end
    e_fill = acc && miss && !mt && fnd;
    e_wb = e_fill && wb;
    if (rok) m_valid[ridx] = 0;
    if (acc && miss && mt) m_mask[mi] |= (1 << src);
    if (e_fill) begin m_valid[fi] = 1; m_line[fi] = line; m_mask[fi] = 1 << src; end
    @(negedge clk);
    chk({tag, "/R2"}, "fill_valid_o", fill_v, e_fill);
    if (e_fill) begin
      chk({tag, "/R2"}, "fill_idx_o", fill_idx, fi);
      chk({tag, "/R2"}, "fill_line_o", fill_line, line);
    end
    chk({tag, "/R8"}, "wb_valid_o", wb_v, e_wb);
    if (e_wb) chk({tag, "/R8"}, "wb_line_o", wb_line, victim);
    chk({tag, "/R4"}, "retire_valid_o", ret_v, rok);
    if (rok) begin
      chk({tag, "/R4"}, "retire_idx_o", ret_idx, ridx);
      chk({tag, "/R4"}, "retire_line_o", ret_line, e_rline);
      chk({tag, "/R4"}, "retire_srcs_o", ret_srcs, e_rmask);
    end
  endtask

  task automatic idle(string tag);
    cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_line[i] = 0; m_mask[i] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "block_o", block, 0);
    chk("R1", "req_ready_o", ready, 1);
    chk("R1", "fill_valid_o", fill_v, 0);
    chk("R1", "wb_valid_o", wb_v, 0);
    chk("R1", "retire_valid_o", ret_v, 0);
    rst_n = 1;
    @(negedge clk);
    // R7 hit changes nothing
    cyc("R7", 1, 0, 'h100, 0, 1, 'h55, 0, 0, 0);
    // R2 allocate, R8 write-back with victim
    cyc("R2", 1, 1, 'h100, 0, 0, 0, 0, 0, 0);
    cyc("R8", 1, 1, 'h200, 1, 1, 'h3AA, 0, 0, 0);
    // R3 merge, no write-back even with flag
    cyc("R3", 1, 1, 'h100, 2, 1, 'h77, 0, 0, 0);
    // R4 retire slot 0 with requesters 0 and 2
    cyc("R4", 0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R4", "retire_srcs_o", ret_srcs, 'b0101);
    // R5 stale and out-of-range responses
    cyc("R5", 0, 0, 0, 0, 0, 0, 1, 0, 0);
    cyc("R5", 0, 0, 0, 0, 0, 0, 1, 7, 0);
    // R2 lowest free slot reused
    cyc("R2", 1, 1, 'h300, 3, 0, 0, 0, 0, 0);
    chk("R2", "fill_idx_o", fill_idx, 0);
    for (int k = 0; k < 4; k++) cyc("R2", 1, 1, 'h400 + k, k, 0, 0, 0, 0, 0);
    // R6 full: request refused
    cyc("R6", 1, 1, 'h900, 1, 1, 'h1, 0, 0, 0);
    chk("R6", "fill_valid_o", fill_v, 0);
    // R9 free a slot while buffer full: still blocked
    cyc("R9", 0, 0, 0, 0, 0, 0, 1, 3, 1);
    cyc("R9", 1, 1, 'h901, 1, 0, 0, 0, 0, 1);
    chk("R9", "block_o", block, 1);
    cyc("R9", 1, 1, 'h902, 1, 0, 0, 0, 0, 0);
    chk("R9", "fill_idx_o", fill_idx, 3);
    // R10 miss to a line retiring this cycle opens a new slot
    cyc("R10", 0, 0, 0, 0, 0, 0, 1, 2, 0);
    cyc("R10", 1, 1, 'h300, 2, 0, 0, 1, 0, 0);
    chk("R10", "fill_valid_o", fill_v, 1);
    chk("R10", "fill_idx_o", fill_idx, 2);
    // R6 buffer full alone blocks a non-full file
    cyc("R6", 1, 1, 'hA00, 0, 0, 0, 0, 0, 1);
    chk("R6", "fill_valid_o", fill_v, 0);
    // mixed traffic
    for (int k = 0; k < 400; k++)
      cyc("mix", $urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0,
          'h500 + $urandom_range(0, 9), $urandom_range(0, NS - 1),
          $urandom_range(0, 1), $urandom_range(0, 'hFFFF),
          $urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 7) == 0);
    // drain
    for (int i = 0; i < N; i++) cyc("R4", 0, 0, 0, 0, 0, 0, 1, i, 0);
    idle("R1");
    chk("R1", "block_o", block, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule